// File: doc/BRIEF.md
# T1 Transmit Framer with Alarm and Test Corruption

This block produces the outgoing serial T1 stream, one bit per clock. Each 193-bit frame opens with a framing bit, followed by 24 channels of eight bits. Bit 1 of each channel is the MSB and is sent first. Frames are grouped into a 12-frame D4 superframe or a 24-frame ESF multiframe. The block asks for each channel byte one cycle before the byte goes out. It may then force bit 7 high in an all-zero byte, or clear bit 2 to signal a yellow alarm. It fills every framing position from its internal patterns or from its inputs.

For line testing, the block can invert the framing bits that carry alignment. These are the Ft bits in D4 and the FPS bits in ESF. It can invert a burst of three such bits after a rising edge on one input. It can also invert one such bit in every 128 while a second input is held high. The mode and option inputs are sampled only at superframe boundaries, so a superframe never mixes two settings. Frame-start and superframe-start strobes mark the framing bit of each frame.

Top module: `t1_tx_framer`

## Requirements
- R1: After reset the first superframe runs with defaults: D4, Fs from `fs_pattern`, no alarm and no zero suppression, whatever the option inputs hold. Option inputs present on the last bit of a superframe govern the whole next superframe.
- R2: A frame is 193 cycles. `frame_start` is high on the framing-bit cycle. `sf_start` is high on the framing bit of superframe frame 1. `ch_load` is high on the cycle before each channel's first bit, and `ch_byte` is taken on that clock. Channel bits follow MSB first.
- R3: D4 frames 1,3,5,7,9,11 carry Ft values 1,0,1,0,1,0. With Fs insertion off, frames 2,4,6,8,10,12 carry Fs values 0,0,1,1,1,0.
- R4: In D4 with Fs insertion on, frame 2j+2 carries `fs_pattern[j]`. In ESF the insertion enable has no effect.
- R5: ESF frames 4,8,12,16,20,24 carry FPS values 0,0,1,0,1,1. Frames 2,6,10,14,18,22 carry `crc_bit`, the odd frames carry `dl_bit`, and the multiframe is 24 frames long.
- R6: With zero suppression on, a channel byte of 0x00 is sent with bit 7 (byte bit 1) set to 1. With it off, bytes pass unchanged.
- R7: In D4 with yellow alarm on and method select 0, bit 2 (byte bit 6) of every channel is sent as 0.
- R8: In D4 with yellow alarm on and method select 1, the Fs position of frame 12 is sent as 1.
- R9: A rising edge on `fbit_burst` inverts the next three Ft (D4) or FPS (ESF) bits, and no more while the input stays high.
- R10: While `fbit_periodic` is high, the first governing framing bit is inverted and then every 128th one after it. When the input is low, no such bit is inverted.
- R11: A framing bit hit by both corruption sources is inverted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1 = ESF multiframe, 0 = D4 superframe |
| zs_en | input | 1 | Bit-7 zero suppression enable |
| yel_alarm | input | 1 | Send yellow alarm (D4) |
| yel_sbit_sel | input | 1 | Yellow method: 0 = clear bit 2, 1 = Fs of frame 12 |
| fs_ins_en | input | 1 | Take D4 Fs bits from `fs_pattern` |
| fs_pattern | input | 6 | Fs values, bit j for frame 2j+2 |
| dl_bit | input | 1 | ESF data-link bit for odd frames |
| crc_bit | input | 1 | ESF check bit for frames 2,6,...,22 |
| fbit_burst | input | 1 | Rising edge starts a three-bit corruption burst |
| fbit_periodic | input | 1 | Level enables one-in-128 corruption |
| ch_byte | input | 8 | Channel byte, taken when `ch_load` is high |
| ch_load | output | 1 | Next channel byte is taken on this clock |
| tx_bit | output | 1 | Serial T1 output |
| frame_start | output | 1 | Framing-bit cycle |
| sf_start | output | 1 | Framing bit of the first frame of a superframe |

## Verification
The bench changes options in the middle of a superframe. A design that applied them at once would break the frame count or the pattern before the boundary. It also switches D4 to ESF and back, where a wrong wrap length shows up as a superframe of the wrong size. The burst input is held high for a whole superframe: a design that keyed on level rather than edge would go on corrupting. A periodic run of 130 governing bits must give exactly two inversions, and a design that counted every framing bit would give a different number. Both sources are then raised on the same bit, and a design that XORed them twice would send that bit unchanged.

// File: rtl/t1_tx_framer.sv
module t1_tx_framer #(
  parameter int CORR_PERIOD = 128,
  parameter int BURST_LEN   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       esf_mode,
  input  logic       zs_en,
  input  logic       yel_alarm,
  input  logic       yel_sbit_sel,
  input  logic       fs_ins_en,
  input  logic [5:0] fs_pattern,
  input  logic       dl_bit,
  input  logic       crc_bit,
  input  logic       fbit_burst,
  input  logic       fbit_periodic,
  input  logic [7:0] ch_byte,
  output logic       ch_load,
  output logic       tx_bit,
  output logic       frame_start,
  output logic       sf_start
);
  localparam int LAST_POS = 192;
  localparam int PW = $clog2(CORR_PERIOD);
  localparam int BW = $clog2(BURST_LEN + 1);
  localparam logic [7:0] FT_PAT  = 8'b0001_0101;
  localparam logic [7:0] FS_PAT  = 8'b0001_1100;
  localparam logic [7:0] FPS_PAT = 8'b0011_0100;

  logic [7:0] pos;
  logic [4:0] frm;
  logic [7:0] sh;
  logic c_esf, c_zs, c_yel, c_ysel, c_fs;
  logic f1_q;
  logic [BW-1:0] burst;
  logic [PW-1:0] per;
  logic [7:0] nb;
  logic fbit;

  wire [7:0] fs_ext   = {2'b00, fs_pattern};
  wire last_bit = (pos == 8'(LAST_POS));
  wire last_frm = c_esf ? (frm == 5'd23) : (frm == 5'd11);
  wire gov      = frame_start && (c_esf ? (frm[1:0] == 2'b11) : !frm[0]);
  wire rise1    = fbit_burst && !f1_q;
  wire hit      = gov && ((burst != '0) || (fbit_periodic && per == '0));

  assign frame_start = (pos == 8'd0);
  assign sf_start    = frame_start && (frm == 5'd0);
  assign ch_load     = (pos[2:0] == 3'd0) && !last_bit;
  assign tx_bit      = frame_start ? (fbit ^ hit) : sh[7];

  always_comb begin
    if (c_esf) begin
      if (frm[1:0] == 2'b11) fbit = FPS_PAT[frm[4:2]];
      else if (frm[0])       fbit = crc_bit;
      else                   fbit = dl_bit;
    end else if (!frm[0]) begin
      fbit = FT_PAT[frm[3:1]];
    end else if (c_yel && c_ysel && frm == 5'd11) begin
      fbit = 1'b1;
    end else begin
      fbit = c_fs ? fs_ext[frm[3:1]] : FS_PAT[frm[3:1]];
    end
  end

  always_comb begin
    nb = ch_byte;
    if (c_zs && ch_byte == 8'd0) nb[1] = 1'b1;
    if (!c_esf && c_yel && !c_ysel) nb[6] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; frm <= '0; sh <= '0;
      c_esf <= 1'b0; c_zs <= 1'b0; c_yel <= 1'b0; c_ysel <= 1'b0; c_fs <= 1'b1;
      f1_q <= 1'b0; burst <= '0; per <= '0;
    end else begin
      pos <= last_bit ? 8'd0 : pos + 8'd1;
      if (last_bit) begin
        frm <= last_frm ? 5'd0 : frm + 5'd1;
        if (last_frm) begin
          c_esf <= esf_mode; c_zs <= zs_en; c_yel <= yel_alarm;
          c_ysel <= yel_sbit_sel; c_fs <= fs_ins_en;
        end
      end
      sh <= ch_load ? nb : {sh[6:0], 1'b0};
      f1_q <= fbit_burst;
      if (rise1) burst <= BW'(BURST_LEN);
      else if (gov && burst != '0) burst <= burst - 1'b1;
      if (!fbit_periodic) per <= '0;
      else if (gov) per <= (per == PW'(CORR_PERIOD - 1)) ? '0 : per + 1'b1;
    end
  end

  p_frame_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start) else $error("frame start twice");
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load && c_zs && ch_byte == 8'd0) |=> sh[1]) else $error("zero byte not stuffed");
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load && !c_zs && (c_esf || !c_yel || c_ysel)) |=> sh == $past(ch_byte))
    else $error("byte altered");
  p_bit2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load && !c_esf && c_yel && !c_ysel) |=> !sh[6]) else $error("bit 2 not cleared");
  p_sbit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !c_esf && c_yel && c_ysel && frm == 5'd11) |-> tx_bit)
    else $error("frame 12 alarm missing");
  p_burst_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gov && burst == BW'(1) && !rise1) |=> burst == '0) else $error("burst too long");
  p_per_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_periodic |=> per == '0) else $error("period count kept");
endmodule

// File: tb/t1_tx_framer_test.sv
module t1_tx_framer_test;
  localparam int PER = 128;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esf_mode, zs_en, yel_alarm, yel_sbit_sel, fs_ins_en;
  logic [5:0] fs_pattern;
  logic dl_bit, crc_bit, fbit_burst, fbit_periodic;
  logic [7:0] ch_byte;
  logic ch_load, tx_bit, frame_start, sf_start;

  t1_tx_framer uut (.clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .zs_en(zs_en),
    .yel_alarm(yel_alarm), .yel_sbit_sel(yel_sbit_sel), .fs_ins_en(fs_ins_en),
    .fs_pattern(fs_pattern), .dl_bit(dl_bit), .crc_bit(crc_bit),
    .fbit_burst(fbit_burst), .fbit_periodic(fbit_periodic), .ch_byte(ch_byte),
    .ch_load(ch_load), .tx_bit(tx_bit), .frame_start(frame_start), .sf_start(sf_start));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit nx_esf = 1, nx_zs = 1, nx_yel = 0, nx_ysel = 0, nx_fs = 0, nx_f1 = 0, nx_f2 = 0;
  logic [5:0] nx_pat = 6'b010101;

  int FT[6]  = '{1, 0, 1, 0, 1, 0};
  int FS[6]  = '{0, 0, 1, 1, 1, 0};
  int FPS[6] = '{0, 0, 1, 0, 1, 1};

  int m_pos = 0, m_frm = 0, m_burst = 0, m_per = 0;
  bit k_esf = 0, k_zs = 0, k_yel = 0, k_ysel = 0, k_fs = 1, m_f1q = 0, m_z = 0, m_a = 0;
  logic [7:0] m_sh = 8'd0;
  logic [15:0] lfsr = 16'hACE1;
  int n_gov = 0, n_inv = 0, n_sf = 0, fcount = 0, last_len = 0, n_z = 0, n_a = 0, n_s = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (pos %0d frame %0d)", req, act, exp, m_pos, m_frm + 1);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int nom, expb, ib;
      bit g, inv, pc;
      string tag;
      logic [7:0] b;
      g = 0; inv = 0; tag = "R2";
      if (m_pos == 0) begin
        if (k_esf) begin
          tag = "R5";
          if (m_frm % 4 == 3) begin nom = FPS[m_frm / 4]; g = 1; end
          else if (m_frm % 2 == 1) nom = crc_bit;
          else nom = dl_bit;
        end else if (m_frm % 2 == 0) begin
          nom = FT[m_frm / 2]; g = 1; tag = "R3";
        end else if (k_yel && k_ysel && m_frm == 11) begin
          nom = 1; tag = "R8"; n_s++;
        end else if (k_fs) begin
          nom = fs_pattern[(m_frm - 1) / 2]; tag = "R4";
        end else begin
          nom = FS[(m_frm - 1) / 2]; tag = "R3";
        end
        pc = fbit_periodic && m_per == 0;
        inv = g && (m_burst > 0 || pc);
        if (inv) tag = (m_burst > 0 && pc) ? "R11" : (m_burst > 0 ? "R9" : "R10");
        expb = nom ^ int'(inv);
        if (g) begin
          n_gov++;
          if (int'(tx_bit) != nom) n_inv++;
        end
      end else begin
        ib = (m_pos - 1) % 8;
        expb = m_sh[7];
        if (m_z && ib == 6) tag = "R6";
        if (m_a && ib == 1) tag = "R7";
      end
      chk(int'(tx_bit) == expb, tag, tx_bit, expb);
      chk(frame_start == (m_pos == 0), "R2", frame_start, m_pos == 0);
      chk(sf_start == (m_pos == 0 && m_frm == 0), "R2", sf_start, m_pos == 0 && m_frm == 0);
      chk(ch_load == (m_pos % 8 == 0 && m_pos != 192), "R2", ch_load, m_pos % 8 == 0 && m_pos != 192);
      if (sf_start) begin
        if (n_sf > 0) last_len = fcount;
        fcount = 1; n_sf++;
      end else if (frame_start) fcount++;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ch_byte = (lfsr[1:0] == 2'b00) ? 8'd0 : lfsr[15:8];
    dl_bit = lfsr[4]; crc_bit = lfsr[7];
    esf_mode = nx_esf; zs_en = nx_zs; yel_alarm = nx_yel; yel_sbit_sel = nx_ysel;
    fs_ins_en = nx_fs; fs_pattern = nx_pat; fbit_burst = nx_f1; fbit_periodic = nx_f2;
    if (rst_n) begin
      bit g2;
      logic [7:0] b2;
      g2 = (m_pos == 0) && (k_esf ? (m_frm % 4 == 3) : (m_frm % 2 == 0));
      if (m_pos % 8 == 0 && m_pos != 192) begin
        b2 = ch_byte;
        m_z = k_zs && b2 == 8'd0;
        m_a = !k_esf && k_yel && !k_ysel;
        if (m_z) begin b2[1] = 1'b1; n_z++; end
        if (m_a) begin b2[6] = 1'b0; n_a++; end
        m_sh = b2;
      end else m_sh = m_sh << 1;
      if (fbit_burst && !m_f1q) m_burst = 3;
      else if (g2 && m_burst > 0) m_burst--;
      m_f1q = fbit_burst;
      if (!fbit_periodic) m_per = 0;
      else if (g2) m_per = (m_per + 1) % PER;
      if (m_pos == 192) begin
        m_pos = 0;
        if (m_frm == (k_esf ? 23 : 11)) begin
          m_frm = 0;
          k_esf = esf_mode; k_zs = zs_en; k_yel = yel_alarm; k_ysel = yel_sbit_sel; k_fs = fs_ins_en;
        end else m_frm++;
      end else m_pos++;
    end
  end

  task automatic wait_sf(input int k);
    while (n_sf < k) @(posedge clk);
    #1;
  endtask

  task automatic wait_gov(input int k);
    int g0;
    g0 = n_gov;
    while (n_gov - g0 < k) begin @(negedge clk); #1; end
  endtask

  initial begin
    int i0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(frame_start == 1'b1, "R1", frame_start, 1);
    chk(sf_start == 1'b1, "R1", sf_start, 1);
    chk(tx_bit == 1'b1, "R1", tx_bit, 1);
    wait_sf(2);
    chk(last_len == 12, "R1", last_len, 12);
    nx_fs = 1;
    wait_sf(3);
    chk(last_len == 24, "R5", last_len, 24);
    nx_esf = 0; nx_fs = 0; nx_zs = 1; nx_yel = 1; nx_ysel = 0;
    wait_sf(4);
    chk(last_len == 24, "R5", last_len, 24);
    nx_ysel = 1; nx_zs = 0; nx_fs = 1;
    wait_sf(5);
    chk(last_len == 12, "R3", last_len, 12);
    nx_yel = 0;
    wait_sf(6);
    chk(n_z > 0, "R6", n_z, 1);
    chk(n_a > 0, "R7", n_a, 1);
    chk(n_s > 0, "R8", n_s, 1);
    repeat (300) @(posedge clk);
    #1 i0 = n_inv; nx_f1 = 1;
    wait_gov(8);
    nx_f1 = 0;
    wait_gov(4);
    chk(n_inv - i0 == 3, "R9", n_inv - i0, 3);
    nx_f2 = 1;
    @(negedge clk); #1;
    i0 = n_inv;
    wait_gov(130);
    nx_f2 = 0;
    wait_gov(4);
    chk(n_inv - i0 == 2, "R10", n_inv - i0, 2);
    nx_f1 = 1; nx_f2 = 1;
    @(negedge clk); #1;
    i0 = n_inv;
    wait_gov(8);
    nx_f1 = 0; nx_f2 = 0;
    wait_gov(4);
    chk(n_inv - i0 == 3, "R11", n_inv - i0, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule